// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM Generator

This block produces two independent pulse-width-modulated outputs. Each channel is described by a pair of 16-bit counts: one for the number of divided ticks the output stays high, and one for the number of divided ticks it stays low. The channel repeats high-then-low indefinitely. The divided tick comes from one of four tick strobes. Each strobe is a single-cycle enable pulse in the system clock domain. A 7-bit prescaler thins the chosen strobe, and a gate bit can freeze the prescaler and the waveform counters.

Software writes three 32-bit words through a simple write port: one timing word per channel and a shared control word. Per channel, the control word holds the output enable, the tick-source select, the prescale value, the gate, an inversion bit and a constant-level mode. Constant-level mode lets a channel sit at a fixed level without the single-tick pulse that a zero-length phase would otherwise produce. Clearing an enable silences that channel right away, without waiting for the current period to end.

Top module: `pwm_dual`

## Requirements
- R1: After reset, all three registers read as zero in effect: both channels are disabled, not inverted, and both outputs are low.
- R2: Writes decode by byte address. 0x0 is channel 0's timing word, 0x4 is channel 1's timing word, and 0x8 is the control word. In a timing word, bits 31:16 are the high count and bits 15:0 are the low count. A write to any other address changes nothing.
- R3: The control word's tick-source select is bits 5:4 for channel 0 and bits 7:6 for channel 1, and it indexes `tick_src`. The prescale value N is bits 14:8 for channel 0 and bits 22:16 for channel 1. Every N+1 selected strobes produce one divided tick.
- R4: Control bit 0 enables channel 0 and bit 1 enables channel 1. When a channel is enabled, its output is high for H divided ticks and then low for L divided ticks, repeating. Setting the enable starts the channel at the beginning of the high phase.
- R5: Control bit 15 gates channel 0 and bit 23 gates channel 1. While a channel's gate bit is clear, no divided tick occurs and its prescaler, phase and counts hold.
- R6: Control bit 28 sets constant mode for channel 0 and bit 29 for channel 1. In constant mode the enabled output holds a steady level: high when the in-use high count is nonzero, and low otherwise.
- R7: A control write that clears a channel's enable makes that channel's output inactive right after the clock edge that takes the write, in any phase.
- R8: Control bit 26 inverts channel 0 and bit 27 inverts channel 1. Inversion complements the enabled waveform, and it makes a disabled channel drive high.
- R9: High and low counts written while a channel runs take effect only at the next start of a high phase.
- R10: Outside constant mode, a phase whose count is zero still lasts one divided tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| tick_src | input | 4 | Tick strobes, one per selectable source |
| pwm_out | output | 2 | Channel outputs, bit 0 for channel 0 |

## Verification
The bench builds the block with the default widths: 16-bit counts, a 7-bit prescaler and a 4-bit address. It drives the four strobes as always-on, every third cycle, never, and every second cycle. It uses small counts and prescale values of zero and two, so a full period spans a few to a few dozen cycles. Within a short run this reaches mid-run count changes, zero-length phases, gate freezes, constant levels and an abrupt disable during the high phase.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  localparam int NCH   = 2;
  localparam int CNT_W = 16;
  localparam int DIV_W = 7;
  localparam int SEL_W = 2;
  localparam int NSRC  = 1 << SEL_W;
  localparam int WORD_W = 2 * CNT_W;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
    logic             gate;
    logic             inv;
    logic             cnst;
  } ch_cfg_t;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_t;
endpackage

// File: rtl/pwm_dual_regs.sv
module pwm_dual_regs
  import pwm_dual_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WORD_W-1:0]           wr_data,
  output ch_cfg_t [NCH-1:0]           cfg,
  output logic [NCH-1:0][CNT_W-1:0]   hi_cnt,
  output logic [NCH-1:0][CNT_W-1:0]   lo_cnt
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(4 * NCH);

  logic [NCH-1:0][WORD_W-1:0] tw_q, tw_d;
  ch_cfg_t [NCH-1:0]          cfg_q, cfg_d;
  logic                       unused_bits;

  // control word bits that hold no field
  assign unused_bits = ^{wr_data[31:30], wr_data[25:24], wr_data[3:2]};

  always_comb begin
    tw_d  = tw_q;
    cfg_d = cfg_q;
    if (wr_en) begin
      for (int c = 0; c < NCH; c++) begin
        if (wr_addr == ADDR_W'(4 * c)) tw_d[c] = wr_data;
      end
      if (wr_addr == CTRL_ADDR) begin
        for (int c = 0; c < NCH; c++) begin
          cfg_d[c].en   = wr_data[c];
          cfg_d[c].sel  = wr_data[4 + SEL_W*c +: SEL_W];
          cfg_d[c].div  = wr_data[8 + 8*c +: DIV_W];
          cfg_d[c].gate = wr_data[15 + 8*c];
          cfg_d[c].inv  = wr_data[26 + c];
          cfg_d[c].cnst = wr_data[28 + c];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tw_q  <= '0;
      cfg_q <= '0;
    end else begin
      tw_q  <= tw_d;
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  for (genvar c = 0; c < NCH; c++) begin : g_split
    assign hi_cnt[c] = tw_q[c][WORD_W-1:CNT_W];
    assign lo_cnt[c] = tw_q[c][CNT_W-1:0];
  end
endmodule

// File: rtl/pwm_dual_prescale.sv
module pwm_dual_prescale #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gate,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] div,
  output logic             dtick
);
  logic [DIV_W-1:0] pcnt_q, pcnt_d;
  logic             adv, wrap;

  assign adv   = en & gate & src_tick;
  assign wrap  = (pcnt_q == div);
  assign dtick = adv & wrap;

  always_comb begin
    pcnt_d = pcnt_q;
    if (!en)      pcnt_d = '0;
    else if (adv) pcnt_d = wrap ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/pwm_dual_wave.sv
module pwm_dual_wave
  import pwm_dual_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dtick,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic             cnst,
  input  logic             inv,
  output logic             pwm
);
  phase_t           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hi_q, hi_d;
  logic [CNT_W-1:0] lo_q, lo_d;
  logic [CNT_W:0]   cnt_inc;
  logic             hi_done, lo_done, level;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign hi_done = cnt_inc >= {1'b0, hi_q};
  assign lo_done = cnt_inc >= {1'b0, lo_q};

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    hi_d  = hi_q;
    lo_d  = lo_q;
    if (!en) begin
      ph_d  = PH_HIGH;
      cnt_d = '0;
      hi_d  = hi_cnt;
      lo_d  = lo_cnt;
    end else if (dtick) begin
      if (ph_q == PH_HIGH) begin
        if (hi_done) begin
          ph_d  = PH_LOW;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end else begin
        if (lo_done) begin
          ph_d  = PH_HIGH;
          cnt_d = '0;
          hi_d  = hi_cnt;
          lo_d  = lo_cnt;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_HIGH;
      cnt_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

  assign level = cnst ? (hi_q != '0) : (ph_q == PH_HIGH);
  assign pwm   = (en & level) ^ inv;
endmodule

// File: rtl/pwm_dual.sv
module pwm_dual
  import pwm_dual_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [NSRC-1:0]   tick_src,
  output logic [NCH-1:0]    pwm_out
);
  ch_cfg_t [NCH-1:0]         cfg;
  logic [NCH-1:0][CNT_W-1:0] hi_cnt, lo_cnt;
  logic [NCH-1:0]            en_v, gate_v, inv_v, cnst_v, dtick_v;

  pwm_dual_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg     (cfg),
    .hi_cnt  (hi_cnt),
    .lo_cnt  (lo_cnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign en_v[c]   = cfg[c].en;
    assign gate_v[c] = cfg[c].gate;
    assign inv_v[c]  = cfg[c].inv;
    assign cnst_v[c] = cfg[c].cnst;

    pwm_dual_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg[c].en),
      .gate     (cfg[c].gate),
      .src_tick (tick_src[cfg[c].sel]),
      .div      (cfg[c].div),
      .dtick    (dtick_v[c])
    );

    pwm_dual_wave u_wave (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cfg[c].en),
      .dtick  (dtick_v[c]),
      .hi_cnt (hi_cnt[c]),
      .lo_cnt (lo_cnt[c]),
      .cnst   (cfg[c].cnst),
      .inv    (cfg[c].inv),
      .pwm    (pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_dual_chk.sv
module pwm_dual_chk
  import pwm_dual_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH-1:0]    en_v,
  input logic [NCH-1:0]    gate_v,
  input logic [NCH-1:0]    inv_v,
  input logic [NCH-1:0]    cnst_v,
  input logic [NCH-1:0]    dtick_v
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(4 * NCH);

  for (genvar c = 0; c < NCH; c++) begin : g_prop
    // R8: a disabled channel rests at its inversion level
    p_off_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_v[c] |-> pwm_out[c] == inv_v[c]);

    // R5: no divided tick while the gate is clear
    p_gate_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_v[c] |-> !dtick_v[c]);

    // R5: output frozen while gated off
    p_gate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_v[c] && !gate_v[c] && $past(en_v[c] && !gate_v[c]) &&
       $stable(cnst_v[c]) && $stable(inv_v[c])) |-> $stable(pwm_out[c]));

    // R6: constant mode holds a steady level between reloads
    p_const_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_v[c] && cnst_v[c] && $past(en_v[c] && cnst_v[c]) &&
       !$past(dtick_v[c]) && $stable(inv_v[c])) |-> $stable(pwm_out[c]));

    // R7: clearing the enable silences the channel after the write edge
    p_stop_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == CTRL_ADDR && !wr_data[c]) |=>
        pwm_out[c] == $past(wr_data[26 + c]));
  end
endmodule

bind pwm_dual pwm_dual_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .pwm_out (pwm_out),
  .en_v    (en_v),
  .gate_v  (gate_v),
  .inv_v   (inv_v),
  .cnst_v  (cnst_v),
  .dtick_v (dtick_v)
);

// File: tb/test_pwm_dual.sv
module test_pwm_dual;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  tick_src = '0;
  logic [1:0]  pwm_out;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  int    wd = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference state
  logic [31:0] m_ctl;
  logic [31:0] m_tw [2];
  int          m_pc [2];
  int          m_ph [2];
  int          m_cnt[2];
  int          m_hl [2];
  int          m_ll [2];

  pwm_dual i_pwm_dual (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tick_src (tick_src),
    .pwm_out  (pwm_out)
  );

  always #10 clk = ~clk;

  // strobes: src0 always, src1 every 3rd, src2 never, src3 every 2nd
  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick_src <= {(cyc % 2) == 0, 1'b0, (cyc % 3) == 0, 1'b1};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = '0;
      for (int c = 0; c < 2; c++) begin
        m_tw[c] = '0; m_pc[c] = 0; m_ph[c] = 1; m_cnt[c] = 0;
        m_hl[c] = 0;  m_ll[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit en, gate, tk, dt;
        int sel, dv;
        en   = m_ctl[c];
        sel  = int'(m_ctl[4 + 2*c +: 2]);
        dv   = int'(m_ctl[8 + 8*c +: 7]);
        gate = m_ctl[15 + 8*c];
        tk   = tick_src[sel];
        if (!en) begin
          m_pc[c] = 0; m_ph[c] = 1; m_cnt[c] = 0;
          m_hl[c] = int'(m_tw[c][31:16]);
          m_ll[c] = int'(m_tw[c][15:0]);
        end else begin
          dt = gate && tk && (m_pc[c] == dv);
          if (gate && tk) m_pc[c] = (m_pc[c] == dv) ? 0 : m_pc[c] + 1;
          if (dt) begin
            if (m_ph[c] == 1) begin
              if (m_cnt[c] + 1 >= m_hl[c]) begin m_ph[c] = 0; m_cnt[c] = 0; end
              else m_cnt[c] = m_cnt[c] + 1;
            end else begin
              if (m_cnt[c] + 1 >= m_ll[c]) begin
                m_ph[c] = 1; m_cnt[c] = 0;
                m_hl[c] = int'(m_tw[c][31:16]);
                m_ll[c] = int'(m_tw[c][15:0]);
              end else m_cnt[c] = m_cnt[c] + 1;
            end
          end
        end
      end
      if (wr_en) begin
        case (wr_addr)
          4'h0: m_tw[0] = wr_data;
          4'h4: m_tw[1] = wr_data;
          4'h8: m_ctl   = wr_data;
          default: ;
        endcase
      end
    end
  end

  function automatic bit exp_out(int c);
    bit lvl;
    if (m_ctl[28 + c]) lvl = (m_hl[c] != 0);
    else               lvl = (m_ph[c] != 0);
    return (m_ctl[c] & lvl) ^ m_ctl[26 + c];
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      for (int c = 0; c < 2; c++) check(cur_req, int'(pwm_out[c]), int'(exp_out(c)));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 50000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    bit pat[6];
    bit v;
    int guard;
    pat = '{1, 1, 1, 0, 0, 1};
    idle(3);
    check("R1", int'(pwm_out), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    idle(5);
    check("R1", int'(pwm_out), 0);

    // R4 basic waveform, src0, divide by 1, H=3 L=2
    cur_req = "R4";
    wr(4'h0, 32'h0003_0002);
    wr(4'h8, 32'h0000_8001);
    for (int i = 0; i < 6; i++) begin
      check("R4", int'(pwm_out[0]), int'(pat[i]));
      @(negedge clk);
    end
    idle(20);

    // R3 channel 1 on src1, divide by 3, H=2 L=4
    cur_req = "R3";
    wr(4'h4, 32'h0002_0004);
    wr(4'h8, 32'h0082_8043);
    idle(120);

    // R9 counts changed mid-run
    cur_req = "R9";
    wr(4'h0, 32'h0001_0005);
    idle(40);

    // R5 gate off freezes channel 0
    cur_req = "R5";
    wr(4'h8, 32'h0082_0043);
    v = pwm_out[0];
    for (int i = 0; i < 20; i++) begin
      check("R5", int'(pwm_out[0]), int'(v));
      @(negedge clk);
    end
    wr(4'h8, 32'h0082_8043);
    idle(10);

    // R6 constant mode, low count zero then high count zero
    cur_req = "R6";
    wr(4'h0, 32'h0004_0000);
    wr(4'h8, 32'h1082_8043);
    idle(30);
    for (int i = 0; i < 10; i++) begin
      check("R6", int'(pwm_out[0]), 1);
      @(negedge clk);
    end
    wr(4'h0, 32'h0000_0006);
    idle(30);
    for (int i = 0; i < 10; i++) begin
      check("R6", int'(pwm_out[0]), 0);
      @(negedge clk);
    end

    // R10 zero high count without constant mode
    cur_req = "R10";
    wr(4'h8, 32'h0082_8043);
    wr(4'h0, 32'h0000_0003);
    idle(30);

    // R8 inversion on channel 1, then disabled inverted
    cur_req = "R8";
    wr(4'h8, 32'h0882_8043);
    idle(60);
    wr(4'h8, 32'h0880_8041);
    check("R8", int'(pwm_out[1]), 1);
    idle(10);

    // R7 disable during the high phase
    cur_req = "R7";
    wr(4'h0, 32'h0005_0005);
    idle(12);
    guard = 0;
    while (pwm_out[0] != 1'b1 && guard < 40) begin
      @(negedge clk);
      guard++;
    end
    check("R7", int'(pwm_out[0]), 1);
    wr(4'h8, 32'h0880_8040);
    check("R7", int'(pwm_out[0]), 0);
    idle(5);

    // R2 unmapped address write ignored
    cur_req = "R2";
    wr(4'hC, 32'hFFFF_FFFF);
    idle(20);
    check("R2", int'(pwm_out), 2);
    wr(4'h8, 32'h0000_8001);
    idle(30);

    done = 1'b1;
    finish_run();
  end
endmodule